// File: doc/BRIEF.md
# Framed Serial Host Port for a Display and Keypad Driver

This block is the host-side serial slave of a display and keypad driver. The host opens every transfer with an eight-bit address. It shifts the address in on a serial clock while chip enable is low, then raises chip enable for the data phase. One address selects a write. The write carries half of the display bit image together with the mode fields: sleep code, key-line select, output-port select and segment blanking. A second address selects a read, which returns the key matrix bits and a sleep-acknowledge bit on a single data output. That output is modelled as the released (1) or pulled-low (0) state of an open-drain pin.

The serial pins are asynchronous to the block clock. They pass through a synchronizer, and edges are detected on the block clock. Written bits are held in a shift register and reach the output latches only when chip enable falls at the end of a frame of the exact length. Outside a frame, the data output tells the host whether the keypad logic has a key read pending. The block has its own initialization reset. The driver's device reset does not act on it, so frames are accepted at any time.

Top module: `lcdk_host_port`

## Requirements
- R1: The address is sampled least significant bit first, on rising serial-clock edges while chip enable is low. The value held when chip enable rises chooses the frame: 42h is a write and 43h is a read.
- R2: Write payload bit positions, in the order received: bits 0 to 44 are display data; 45-46 are the sleep code, 47-48 the key-line select, 49-50 the port select, 51 is segment-off, and 52 is the half select. A half select of 0 loads display bits 0..44 and 1 loads bits 45..89. Each field is received least significant bit first.
- R3: The display and mode outputs change only when chip enable falls at the end of a write frame that had exactly 53 payload clocks. A frame with fewer or more clocks leaves every output unchanged.
- R4: A frame with any other address is ignored and changes no output.
- R5: A write to one display half leaves the other half unchanged.
- R6: In a read frame, key bit 0 appears on the data output once chip enable is high. Each rising serial-clock edge advances by one bit, and bit 30 is the sleep acknowledge. The values are captured when chip enable rises.
- R7: While chip enable is low, the data output is low exactly when a key request is pending.
- R8: While chip enable is high in any frame other than a read, the data output is released high.
- R9: A read that begins with no key request pending returns all zero bits and raises no completion pulse.
- R10: `read_done_o` is a one-cycle pulse that follows the fall of chip enable at the end of a valid read frame with at least 31 payload clocks. It does not pulse for a shorter read.
- R11: After the initialization reset, the display bits and all mode fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock |
| rst_ni | input | 1 | initialization reset, active low |
| ser_ce_i | input | 1 | host chip enable |
| ser_clk_i | input | 1 | host serial clock |
| ser_di_i | input | 1 | host serial data in |
| ser_do_o | output | 1 | serial data out, 1 = released, 0 = pulled low |
| key_bits_i | input | KEY_BITS | key matrix state from the scan logic |
| sleep_ack_i | input | 1 | sleep state at key detection |
| key_req_i | input | 1 | key read request pending |
| read_done_o | output | 1 | pulse after a complete valid read |
| disp_o | output | DISP_BITS | latched display image |
| sleep_code_o | output | 2 | latched sleep code |
| key_line_sel_o | output | 2 | latched key-line / segment select |
| port_sel_o | output | 2 | latched output-port select |
| seg_off_o | output | 1 | latched segment blanking |

## Verification
The bench sweeps all 128 mode-field values. Each sweep step carries its own display pattern and alternates the half select, which exposes swapped field positions, a wrong half and any disturbance of the other half. It also sends frames one clock short and one clock long, and frames with foreign addresses; these separate a bit-count check from a plain edge count. Reads with several key patterns, including a pattern changed during the frame, show bit order, the placement of the acknowledge bit and the capture point. Reads with no pending request and reads cut short test the two ways a read can be refused.

// File: rtl/lcdk_pkg.sv
package lcdk_pkg;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_WRITE = 2'd1,
      FR_READ  = 2'd2,
      FR_SKIP  = 2'd3
   } frame_kind_e;

   typedef struct packed {
      logic [1:0] sleep;
      logic [1:0] keysel;
      logic [1:0] portsel;
      logic       seg_off;
   } mode_s;

   localparam int MODE_W = $bits(mode_s);

endpackage

// File: rtl/lcdk_sync.sv
module lcdk_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   initial begin : chk_params
      if (STAGES < 2) $fatal(1, "lcdk_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $fatal(1, "lcdk_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[0] <= '0;
            else         stage_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lcdk_frame_ctl.sv
module lcdk_frame_ctl
   import lcdk_pkg::*;
#(
   parameter int                ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] WR_CODE = 'h42,
   parameter logic [ADDR_W-1:0] RD_CODE = 'h43,
   parameter int                WR_LEN  = 53,
   parameter int                RD_LEN  = 31
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ce_s_i,
   input  logic              sclk_s_i,
   input  logic              di_s_i,
   output frame_kind_e       kind_o,
   output logic              rd_start_o,
   output logic              shift_rd_o,
   output logic              commit_o,
   output logic              rd_end_o,
   output logic [WR_LEN-1:0] payload_o
);

   localparam int MAXLEN  = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
   localparam int CNT_MAX = MAXLEN + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   initial begin : chk_params
      if (ADDR_W < 1)         $fatal(1, "lcdk_frame_ctl: ADDR_W must be positive");
      if (WR_CODE == RD_CODE) $fatal(1, "lcdk_frame_ctl: codes must differ");
      if (WR_LEN < 2)         $fatal(1, "lcdk_frame_ctl: WR_LEN too small");
      if (RD_LEN < 1)         $fatal(1, "lcdk_frame_ctl: RD_LEN too small");
   end

   logic              ce_q, sclk_q;
   logic              ce_rise, ce_fall, sclk_rise;
   logic [ADDR_W-1:0] addr_q;
   frame_kind_e       kind_q, kind_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [WR_LEN-1:0] pl_q;
   logic              commit_q, rd_end_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ce_q   <= 1'b0;
         sclk_q <= 1'b0;
      end else begin
         ce_q   <= ce_s_i;
         sclk_q <= sclk_s_i;
      end
   end

   assign ce_rise   = ce_s_i & ~ce_q;
   assign ce_fall   = ~ce_s_i & ce_q;
   assign sclk_rise = sclk_s_i & ~sclk_q;

   // address shifter: first bit received ends at position 0
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  addr_q <= '0;
      else if (sclk_rise && !ce_s_i) addr_q <= {di_s_i, addr_q[ADDR_W-1:1]};
   end

   always_comb begin
      kind_d = kind_q;
      if (ce_rise) begin
         if (addr_q == WR_CODE)      kind_d = FR_WRITE;
         else if (addr_q == RD_CODE) kind_d = FR_READ;
         else                        kind_d = FR_SKIP;
      end else if (ce_fall) begin
         kind_d = FR_IDLE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) kind_q <= FR_IDLE;
      else         kind_q <= kind_d;
   end

   // payload clock counter, saturating one past the longest frame
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (ce_rise) begin
         cnt_q <= '0;
      end else if (sclk_rise && ce_s_i && kind_q != FR_IDLE) begin
         if (cnt_q < CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pl_q <= '0;
      else if (sclk_rise && ce_s_i && kind_q == FR_WRITE)
         pl_q <= {di_s_i, pl_q[WR_LEN-1:1]};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         commit_q <= 1'b0;
         rd_end_q <= 1'b0;
      end else begin
         commit_q <= ce_fall && kind_q == FR_WRITE && cnt_q == CNT_W'(WR_LEN);
         rd_end_q <= ce_fall && kind_q == FR_READ  && cnt_q >= CNT_W'(RD_LEN);
      end
   end

   assign kind_o     = kind_q;
   assign rd_start_o = ce_rise && addr_q == RD_CODE;
   assign shift_rd_o = sclk_rise && ce_s_i && kind_q == FR_READ;
   assign commit_o   = commit_q;
   assign rd_end_o   = rd_end_q;
   assign payload_o  = pl_q;

endmodule

// File: rtl/lcdk_key_shift.sv
module lcdk_key_shift #(
   parameter int KEY_BITS = 30
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic                shift_i,
   input  logic                req_i,
   input  logic [KEY_BITS-1:0] keys_i,
   input  logic                ack_i,
   output logic                bit_o,
   output logic                valid_o
);

   localparam int LEN = KEY_BITS + 1;

   initial begin : chk_params
      if (KEY_BITS < 1) $fatal(1, "lcdk_key_shift: KEY_BITS must be positive");
   end

   logic [LEN-1:0] sh_q;
   logic           valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q    <= '0;
         valid_q <= 1'b0;
      end else if (start_i) begin
         sh_q    <= req_i ? {ack_i, keys_i} : '0;
         valid_q <= req_i;
      end else if (shift_i) begin
         sh_q    <= {1'b0, sh_q[LEN-1:1]};
      end
   end

   assign bit_o   = sh_q[0];
   assign valid_o = valid_q;

endmodule

// File: rtl/lcdk_latch.sv
module lcdk_latch
   import lcdk_pkg::*;
#(
   parameter int DISP_BITS = 90,
   parameter int WR_LEN    = DISP_BITS / 2 + MODE_W + 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 commit_i,
   input  logic [WR_LEN-1:0]    payload_i,
   output logic [DISP_BITS-1:0] disp_o,
   output mode_s                mode_o
);

   localparam int HALF  = DISP_BITS / 2;
   localparam int M_LSB = HALF;
   localparam int SEL   = WR_LEN - 1;

   initial begin : chk_params
      if (DISP_BITS % 2 != 0)           $fatal(1, "lcdk_latch: DISP_BITS must be even");
      if (WR_LEN != HALF + MODE_W + 1)  $fatal(1, "lcdk_latch: WR_LEN mismatch");
   end

   logic [HALF-1:0] half_data;
   logic            sel;
   mode_s           mode_d, mode_q;

   assign half_data      = payload_i[HALF-1:0];
   assign sel            = payload_i[SEL];
   assign mode_d.sleep   = payload_i[M_LSB+1 -: 2];
   assign mode_d.keysel  = payload_i[M_LSB+3 -: 2];
   assign mode_d.portsel = payload_i[M_LSB+5 -: 2];
   assign mode_d.seg_off = payload_i[M_LSB+6];

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                      q <= '0;
         else if (commit_i && sel == h[0]) q <= half_data;
      end
      assign disp_o[h*HALF +: HALF] = q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mode_q <= '0;
      else if (commit_i) mode_q <= mode_d;
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/lcdk_host_port.sv
module lcdk_host_port
   import lcdk_pkg::*;
#(
   parameter int DISP_BITS   = 90,
   parameter int KEY_BITS    = 30,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   parameter int WR_CODE     = 'h42,
   parameter int RD_CODE     = 'h43
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 ser_ce_i,
   input  logic                 ser_clk_i,
   input  logic                 ser_di_i,
   output logic                 ser_do_o,
   input  logic [KEY_BITS-1:0]  key_bits_i,
   input  logic                 sleep_ack_i,
   input  logic                 key_req_i,
   output logic                 read_done_o,
   output logic [DISP_BITS-1:0] disp_o,
   output logic [1:0]           sleep_code_o,
   output logic [1:0]           key_line_sel_o,
   output logic [1:0]           port_sel_o,
   output logic                 seg_off_o
);

   localparam int HALF   = DISP_BITS / 2;
   localparam int WR_LEN = HALF + MODE_W + 1;
   localparam int RD_LEN = KEY_BITS + 1;

   initial begin : chk_params
      if (DISP_BITS < 2 || DISP_BITS % 2 != 0) $fatal(1, "lcdk_host_port: bad DISP_BITS");
      if (WR_CODE >= (1 << ADDR_W) || RD_CODE >= (1 << ADDR_W))
         $fatal(1, "lcdk_host_port: address code exceeds ADDR_W");
   end

   logic [2:0]        pins_s;
   logic              ce_s, sclk_s, di_s;
   frame_kind_e       kind;
   logic              rd_start, shift_rd, commit, rd_end;
   logic [WR_LEN-1:0] payload;
   logic              key_bit, snap_valid;
   mode_s             mode;

   lcdk_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({ser_ce_i, ser_clk_i, ser_di_i}),
      .q_o    (pins_s)
   );

   assign {ce_s, sclk_s, di_s} = pins_s;

   lcdk_frame_ctl #(
      .ADDR_W  (ADDR_W),
      .WR_CODE (ADDR_W'(WR_CODE)),
      .RD_CODE (ADDR_W'(RD_CODE)),
      .WR_LEN  (WR_LEN),
      .RD_LEN  (RD_LEN)
   ) u_frame (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ce_s_i     (ce_s),
      .sclk_s_i   (sclk_s),
      .di_s_i     (di_s),
      .kind_o     (kind),
      .rd_start_o (rd_start),
      .shift_rd_o (shift_rd),
      .commit_o   (commit),
      .rd_end_o   (rd_end),
      .payload_o  (payload)
   );

   lcdk_key_shift #(.KEY_BITS(KEY_BITS)) u_keys (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (rd_start),
      .shift_i (shift_rd),
      .req_i   (key_req_i),
      .keys_i  (key_bits_i),
      .ack_i   (sleep_ack_i),
      .bit_o   (key_bit),
      .valid_o (snap_valid)
   );

   lcdk_latch #(.DISP_BITS(DISP_BITS), .WR_LEN(WR_LEN)) u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .payload_i (payload),
      .disp_o    (disp_o),
      .mode_o    (mode)
   );

   always_comb begin
      if (ce_s) ser_do_o = (kind == FR_READ) ? key_bit : 1'b1;
      else      ser_do_o = ~key_req_i;
   end

   assign read_done_o    = rd_end & snap_valid;
   assign sleep_code_o   = mode.sleep;
   assign key_line_sel_o = mode.keysel;
   assign port_sel_o     = mode.portsel;
   assign seg_off_o      = mode.seg_off;

endmodule

// File: rtl/lcdk_host_port_chk.sv
module lcdk_host_port_chk
   import lcdk_pkg::*;
#(
   parameter int DISP_BITS = 90
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 ce_s,
   input frame_kind_e          kind,
   input logic                 commit,
   input logic                 ser_do_o,
   input logic                 read_done_o,
   input logic [DISP_BITS-1:0] disp_o,
   input logic [MODE_W-1:0]    mode_bits
);

   assert_do_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_s && kind != FR_READ) |-> ser_do_o);

   assert_disp_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit |=> $stable(disp_o));

   assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit |=> $stable(mode_bits));

   assert_skip_no_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind == FR_SKIP) |=> !commit);

   assert_commit_from_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |-> $past(kind) == FR_WRITE);

   assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      read_done_o |=> !read_done_o);

   assert_done_after_ce_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      read_done_o |-> !ce_s);

endmodule

bind lcdk_host_port lcdk_host_port_chk #(.DISP_BITS(DISP_BITS)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ce_s        (ce_s),
   .kind        (kind),
   .commit      (commit),
   .ser_do_o    (ser_do_o),
   .read_done_o (read_done_o),
   .disp_o      (disp_o),
   .mode_bits   ({sleep_code_o, key_line_sel_o, port_sel_o, seg_off_o})
);

// File: tb/test_lcdk_host_port.sv
module test_lcdk_host_port;

   localparam int DISP = 90;
   localparam int KEYS = 30;
   localparam int HALF = DISP / 2;
   localparam int WLEN = HALF + 8;
   localparam int RLEN = KEYS + 1;
   localparam int HP   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ce = 1'b0, sclk = 1'b0, di = 1'b0;
   logic            ser_do;
   logic [KEYS-1:0] keys = '0;
   logic            ack = 1'b0, req = 1'b0;
   logic            done;
   logic [DISP-1:0] disp;
   logic [1:0]      slp, ksel, psel;
   logic            segoff;

   int checks = 0, errors = 0, done_cnt = 0, hi_bad = 0;
   bit finished = 0;
   logic [DISP-1:0] exp_disp = '0;
   logic [6:0]      exp_mode = '0;

   always #10 clk = ~clk;

   lcdk_host_port i_lcdk_host_port (
      .clk_i (clk), .rst_ni (rst_n),
      .ser_ce_i (ce), .ser_clk_i (sclk), .ser_di_i (di), .ser_do_o (ser_do),
      .key_bits_i (keys), .sleep_ack_i (ack), .key_req_i (req),
      .read_done_o (done), .disp_o (disp),
      .sleep_code_o (slp), .key_line_sel_o (ksel), .port_sel_o (psel),
      .seg_off_o (segoff)
   );

   always @(posedge clk) if (rst_n && done) done_cnt++;

   task automatic chk(input bit ok, input string req_tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ser_bit(input logic b, input bit watch_hi);
      di = b;
      wait_n(HP);
      if (watch_hi && ser_do !== 1'b1) hi_bad++;
      sclk = 1'b1;
      wait_n(HP);
      sclk = 1'b0;
   endtask

   task automatic send_addr(input logic [7:0] a);
      ce = 1'b0;
      for (int i = 0; i < 8; i++) ser_bit(a[i], 1'b0);
      wait_n(HP);
   endtask

   task automatic wr_frame(input logic [7:0] a, input logic [63:0] pl, input int n);
      send_addr(a);
      ce = 1'b1;
      wait_n(HP);
      for (int i = 0; i < n; i++) ser_bit(pl[i], 1'b1);
      wait_n(HP);
      ce = 1'b0;
      wait_n(10);
   endtask

   task automatic rd_frame(input int n, input bit alter, output logic [63:0] got);
      got = '0;
      send_addr(8'h43);
      ce = 1'b1;
      wait_n(HP);
      for (int i = 0; i < n; i++) begin
         got[i] = ser_do;
         if (alter && i == 0) begin
            keys = ~keys;
            ack  = ~ack;
         end
         sclk = 1'b1;
         wait_n(HP);
         sclk = 1'b0;
         wait_n(HP);
      end
      ce = 1'b0;
      wait_n(10);
   endtask

   function automatic logic [63:0] make_pl(input logic [HALF-1:0] d, input logic [6:0] m,
                                           input logic sel);
      logic [63:0] p = '0;
      p[HALF-1:0]     = d;
      p[HALF+6:HALF]  = m;
      p[HALF+7]       = sel;
      return p;
   endfunction

   function automatic logic [6:0] act_mode();
      return {segoff, psel, ksel, slp};
   endfunction

   task automatic check_state(input string req_tag);
      chk(disp === exp_disp, req_tag, 128'(disp), 128'(exp_disp));
      chk(act_mode() === exp_mode, req_tag, 128'(act_mode()), 128'(exp_mode));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [HALF-1:0] d;
      logic [63:0]     got, expv;
      int              prev_done;

      wait_n(5);
      rst_n = 1'b1;
      wait_n(5);

      // R11 reset state
      check_state("R11");
      chk(ser_do === 1'b1, "R11", 128'(ser_do), 128'(1));
      chk(done === 1'b0, "R11", 128'(done), 128'(0));

      // R7 idle request flag
      req = 1'b1; wait_n(2);
      chk(ser_do === 1'b0, "R7", 128'(ser_do), 128'(0));
      req = 1'b0; wait_n(2);
      chk(ser_do === 1'b1, "R7", 128'(ser_do), 128'(1));

      // R1 R2 R5 sweep of all mode values, alternating halves
      for (int c = 0; c < 128; c++) begin
         for (int i = 0; i < HALF; i++) d[i] = (((i * (c + 5) + c) % 7) < 3);
         hi_bad = 0;
         wr_frame(8'h42, make_pl(d, 7'(c), c[0]), WLEN);
         if (c[0]) exp_disp[DISP-1:HALF] = d;
         else      exp_disp[HALF-1:0]    = d;
         exp_mode = 7'(c);
         check_state(c == 0 ? "R1" : (c[0] ? "R5" : "R2"));
         if (c % 32 == 0) chk(hi_bad == 0, "R8", 128'(hi_bad), 128'(0));
      end

      // R3 frames one clock short and one clock long
      wr_frame(8'h42, make_pl('1, 7'h55, 1'b0), WLEN - 1);
      check_state("R3");
      wr_frame(8'h42, make_pl('1, 7'h2A, 1'b1), WLEN + 1);
      check_state("R3");

      // R4 foreign addresses, R8 output released during them
      hi_bad = 0;
      wr_frame(8'h44, make_pl('1, 7'h7F, 1'b0), WLEN);
      check_state("R4");
      wr_frame(8'hC2, make_pl('0, 7'h00, 1'b1), WLEN);
      check_state("R4");
      chk(hi_bad == 0, "R8", 128'(hi_bad), 128'(0));

      // R6 R10 valid reads with several key patterns
      req = 1'b1;
      for (int p = 0; p < 3; p++) begin
         keys = (p == 0) ? 30'h2AAAAAAA : (p == 1) ? 30'h0F0F0F0F : 30'h3FFFFFFF;
         ack  = (p != 1);
         prev_done = done_cnt;
         rd_frame(RLEN, 1'b0, got);
         expv = 64'({ack, keys});
         chk(got === expv, "R6", 128'(got), 128'(expv));
         chk(done_cnt == prev_done + 1, "R10", 128'(done_cnt - prev_done), 128'(1));
      end

      // R6 capture at chip enable rise: inputs flip during the frame
      keys = 30'h12345678;
      ack  = 1'b0;
      expv = 64'({1'b0, 30'h12345678});
      rd_frame(RLEN, 1'b1, got);
      chk(got === expv, "R6", 128'(got), 128'(expv));

      // R10 short read: no completion pulse
      prev_done = done_cnt;
      rd_frame(RLEN - 11, 1'b0, got);
      chk(done_cnt == prev_done, "R10", 128'(done_cnt - prev_done), 128'(0));

      // R9 read without pending request
      req  = 1'b0;
      keys = '1;
      ack  = 1'b1;
      prev_done = done_cnt;
      rd_frame(RLEN, 1'b0, got);
      chk(got === 64'(0), "R9", 128'(got), 128'(0));
      chk(done_cnt == prev_done, "R9", 128'(done_cnt - prev_done), 128'(0));

      // reads left the latches untouched
      check_state("R4");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule